// File: doc/BRIEF.md
# Serial Peripheral Master with Prepended Reads

This block is a register-programmed serial peripheral master. The host fills a transmit buffer through a small byte-addressed register port, then sets the transfer kind and byte count, then issues a start command. The block then drives one chip-select line for the whole transaction, clocks the bytes out and in using SPI mode 0, stores the received bytes in a receive buffer and raises a done status bit. An interrupt line reports status bits that are enabled in a mask register.

The host cannot keep chip select asserted between two host operations, so reads are handled in a different way. A half-duplex read can carry up to fifteen leading transmit bytes, such as a flash opcode and address. These bytes are sent first, and the read bytes follow inside the same chip-select window. While no transmit data applies, the output line carries a programmable fill byte. In 3-wire mode the output driver is released during the read phase, so that the peripheral can drive the shared line.

Register map (address on `reg_addr`): 0x00 clock configuration, 0x01 fill byte, 0x02 transfer control, 0x03 command, 0x04 status, 0x05 interrupt mask. The transmit buffer is at 0x40 plus the offset (write only), and the receive buffer is at 0x80 plus the offset (read only).

Top module: `spi_prepend_master`

## Requirements
- R1: After reset all chip selects are high, SCK is low, status reads 0, the fill register reads 0xFF and the clock configuration reads 0x10.
- R2: A command write with bits [1:0] = 3 starts a transaction when the block is idle; any other opcode is ignored. Bits [7:4] pick the chip select, and only that line goes low. It stays low and unchanged for the whole transaction.
- R3: Clock configuration bits [2:0] set the bit period in system cycles: code 7 gives 2, code 0 gives 3, code 6 gives 4, code 5 gives 8, code 4 gives 16, code 3 gives 32, code 2 gives 64, code 1 gives 128. SCK is low for the first half of each bit (rounded down), so chip select is low for exactly 8 bit periods per byte.
- R4: Clock configuration bit 7 set means both the sent and the received bytes travel least significant bit first; clear means most significant bit first.
- R5: Transfer type 1 (control bits [7:6] = 1, count in bits [5:0]) sends count bytes from transmit offset 0 upward and leaves the receive buffer untouched.
- R6: Transfer type 0 sends count bytes from the transmit buffer and stores the bytes received at the same time into the receive buffer from offset 0.
- R7: Transfer type 2 with prepend count N (command bits [11:8]) first sends transmit bytes 0..N-1. It then sends count copies of the fill byte and stores the received bytes from receive offset 0. All of this happens under one chip-select assertion.
- R8: With command bit 12 set, `sdo_oe` is high only during the prepend bytes and low during the read bytes. With bit 12 clear, `sdo_oe` stays high throughout.
- R9: Status bit 0 (done) sets in the same cycle that chip select is released. Writing 1 to a status bit clears it. `irq` is high exactly when a status bit and the mask bit at the same position are both set.
- R10: A write to a transmit offset of 63 or more is dropped and sets status bit 3. A start that needs more transmit bytes than the highest offset+1 written since the previous transaction ended sets status bit 2. Status bits 1 and 4 always read 0.
- R11: A start that arrives while a transaction runs is ignored. After chip-select release the block stays busy for (clock configuration bits [5:3]) x (bit period) cycles, and starts in that window are ignored.
- R12: A start with transfer type 3 is ignored. A start with a total byte count of 0 sets done at once and never asserts chip select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| sck | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (3-wire turnaround) |
| sdi | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | Masked status interrupt |

## Verification
The bench goes after the point where a prepended read turns from transmit to fill data. A design that counted the read bytes from the wrong index would send a transmit byte where the fill byte belongs, or store received bytes at a shifted offset, or drop chip select between the two phases. It also measures the chip-select window for every rate code. A wrong divider, or the odd /3 code rounded to /2 or /4, changes that length. Busy and cs-off-gap starts, type 3 starts and zero-length starts are all issued: an implementation that accepts any of them shows an extra chip-select fall or a false done. Underflow and overflow writes prove that the bits tracking buffer fill rise only for the cases stated.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;

  typedef enum logic [1:0] {
    XT_DUPLEX = 2'd0,
    XT_WRITE  = 2'd1,
    XT_READ   = 2'd2,
    XT_RSVD   = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } state_e;

  localparam logic [7:0] A_CFG    = 8'h00;
  localparam logic [7:0] A_FILL   = 8'h01;
  localparam logic [7:0] A_CTRL   = 8'h02;
  localparam logic [7:0] A_CMD    = 8'h03;
  localparam logic [7:0] A_STATUS = 8'h04;
  localparam logic [7:0] A_MASK   = 8'h05;

  // bit period in system cycles for a rate code
  function automatic logic [7:0] bit_period(input logic [2:0] code);
    if (code == 3'd0) return 8'd3;
    return 8'd1 << (4'd8 - {1'b0, code});
  endfunction

endpackage

// File: rtl/spi_pm_clkgen.sv
module spi_pm_clkgen #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic          sck,
  output logic          sample,
  output logic          bit_end
);
  logic [PW-1:0] ph_q, ph_d;
  logic [PW-1:0] half;

  assign half    = period >> 1;
  assign sck     = run && (ph_q >= half);
  assign sample  = run && (ph_q == half);
  assign bit_end = run && (ph_q == period - 1'b1);

  always_comb begin
    ph_d = ph_q;
    if (!run)         ph_d = '0;
    else if (bit_end) ph_d = '0;
    else              ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/spi_pm_shift.sv
module spi_pm_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       lsb_first,
  input  logic       sample,
  input  logic       bit_end,
  input  logic       sdi,
  output logic       sdo,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  logic [7:0] tx_q, tx_d, rx_q, rx_d;
  logic [2:0] bc_q, bc_d;

  assign sdo       = lsb_first ? tx_q[0] : tx_q[7];
  assign byte_done = bit_end && (bc_q == 3'd7);
  assign rx_byte   = rx_d;

  always_comb begin
    tx_d = tx_q;
    bc_d = bc_q;
    rx_d = rx_q;
    if (load) begin
      tx_d = load_byte;
      bc_d = '0;
    end else if (bit_end) begin
      tx_d = lsb_first ? {1'b0, tx_q[7:1]} : {tx_q[6:0], 1'b0};
      bc_d = bc_q + 3'd1;
    end
    if (sample) rx_d = lsb_first ? {sdi, rx_q[7:1]} : {rx_q[6:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
      bc_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
      bc_q <= bc_d;
    end
  end
endmodule

// File: rtl/spi_prepend_master.sv
module spi_prepend_master
  import spi_pm_pkg::*;
#(
  parameter int NUM_CS = 16,
  parameter int DEPTH  = 63,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              sck,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  localparam int SEL_W = $clog2(NUM_CS);
  localparam int IDX_W = CNT_W + 1;
  localparam int OFF_W = $clog2(DEPTH);
  localparam int GAP_W = 11;

  logic [7:0]         cfg_q, fill_q;
  logic [CNT_W+1:0]   ctl_q;
  logic [4:0]         mask_q, stat_q, stat_d;
  logic [7:0]         tx_mem [DEPTH];
  logic [7:0]         rx_mem [DEPTH];
  state_e             state_q, state_d;
  xfer_e              typ_q, ctl_typ, ld_typ;
  logic [IDX_W-1:0]   idx_q, idx_d, nb_q, start_nb, start_need, ld_idx, rx_idx;
  logic [3:0]         pre_q, cmd_pre, ld_pre;
  logic [SEL_W-1:0]   slv_q;
  logic               tw_q, lsb_q;
  logic [7:0]         per_q, ld_byte, rx_byte;
  logic [GAP_W-1:0]   gap_q, gap_d, gap_len;
  logic [IDX_W-1:0]   hwm_q, hwm_d;
  logic               accept, go_run, finish, last, load, rx_we, tx_we, tx_hit;
  logic               sample, bit_end, byte_done, running;
  logic [5:0]         tx_off;
  logic               unused_bits;

  assign unused_bits = ^reg_wdata[15:13];
  assign running  = (state_q == ST_RUN);
  assign ctl_typ  = xfer_e'(ctl_q[CNT_W+1:CNT_W]);
  assign cmd_pre  = reg_wdata[11:8];
  assign accept   = reg_we && (reg_addr == A_CMD) && (reg_wdata[1:0] == 2'b11)
                    && (state_q == ST_IDLE) && (ctl_typ != XT_RSVD);
  assign start_nb   = (ctl_typ == XT_READ) ? IDX_W'(cmd_pre) + IDX_W'(ctl_q[CNT_W-1:0])
                                           : IDX_W'(ctl_q[CNT_W-1:0]);
  assign start_need = (ctl_typ == XT_READ) ? IDX_W'(cmd_pre) : IDX_W'(ctl_q[CNT_W-1:0]);
  assign go_run   = accept && (start_nb != '0);
  assign last     = (idx_q == nb_q - 1'b1);
  assign finish   = running && byte_done && last;
  assign load     = go_run || (running && byte_done && !last);
  assign gap_len  = GAP_W'(cfg_q[5:3]) * GAP_W'(per_q);

  // next byte to shift: transmit data, or the fill byte in the read phase
  assign ld_idx  = running ? idx_q + 1'b1 : '0;
  assign ld_typ  = running ? typ_q : ctl_typ;
  assign ld_pre  = running ? pre_q : cmd_pre;
  assign ld_byte = ((ld_typ == XT_READ && ld_idx >= IDX_W'(ld_pre)) || ld_idx >= IDX_W'(DEPTH))
                   ? fill_q : tx_mem[ld_idx[OFF_W-1:0]];

  assign rx_idx = (typ_q == XT_READ) ? idx_q - IDX_W'(pre_q) : idx_q;
  assign rx_we  = running && byte_done && (rx_idx < IDX_W'(DEPTH)) &&
                  (typ_q == XT_DUPLEX || (typ_q == XT_READ && idx_q >= IDX_W'(pre_q)));
  assign tx_off = reg_addr[5:0];
  assign tx_hit = reg_we && (reg_addr[7:6] == 2'b01);
  assign tx_we  = tx_hit && (tx_off < 6'(DEPTH));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    gap_d   = gap_q;
    hwm_d   = hwm_q;
    stat_d  = stat_q;
    if (reg_we && reg_addr == A_STATUS) stat_d = stat_q & ~reg_wdata[4:0];
    case (state_q)
      ST_IDLE: if (accept) begin
        idx_d = '0;
        if (start_need > hwm_q) stat_d[2] = 1'b1;
        if (go_run) state_d = ST_RUN;
        else begin
          stat_d[0] = 1'b1;
          hwm_d     = '0;
        end
      end
      ST_RUN: if (byte_done) begin
        if (last) begin
          stat_d[0] = 1'b1;
          hwm_d     = '0;
          gap_d     = gap_len;
          state_d   = (gap_len == '0) ? ST_IDLE : ST_GAP;
        end else idx_d = idx_q + 1'b1;
      end
      ST_GAP: begin
        gap_d = gap_q - 1'b1;
        if (gap_q == GAP_W'(1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (tx_hit && !tx_we) stat_d[3] = 1'b1;
    if (tx_we && (IDX_W'(tx_off) + 1'b1 > hwm_d)) hwm_d = IDX_W'(tx_off) + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= 8'h10;
      fill_q  <= 8'hFF;
      ctl_q   <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
      hwm_q   <= '0;
      typ_q   <= XT_DUPLEX;
      nb_q    <= '0;
      pre_q   <= '0;
      slv_q   <= '0;
      tw_q    <= 1'b0;
      lsb_q   <= 1'b0;
      per_q   <= 8'd2;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      gap_q   <= gap_d;
      hwm_q   <= hwm_d;
      stat_q  <= {1'b0, stat_d[3:2], 1'b0, stat_d[0]};
      if (reg_we && reg_addr == A_CFG)  cfg_q  <= reg_wdata[7:0];
      if (reg_we && reg_addr == A_FILL) fill_q <= reg_wdata[7:0];
      if (reg_we && reg_addr == A_CTRL) ctl_q  <= reg_wdata[CNT_W+1:0];
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata[4:0];
      if (accept) begin
        typ_q <= ctl_typ;
        nb_q  <= start_nb;
        pre_q <= cmd_pre;
        slv_q <= reg_wdata[4 +: SEL_W];
        tw_q  <= reg_wdata[12];
        lsb_q <= cfg_q[7];
        per_q <= bit_period(cfg_q[2:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_we) tx_mem[tx_off[OFF_W-1:0]] <= reg_wdata[7:0];
    if (rx_we) rx_mem[rx_idx[OFF_W-1:0]] <= rx_byte;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:    reg_rdata = {8'h00, cfg_q};
      A_FILL:   reg_rdata = {8'h00, fill_q};
      A_CTRL:   reg_rdata = 16'(ctl_q);
      A_STATUS: reg_rdata = {11'h000, stat_q};
      A_MASK:   reg_rdata = {11'h000, mask_q};
      default:
        if (reg_addr[7:6] == 2'b10 && reg_addr[5:0] < 6'(DEPTH))
          reg_rdata = {8'h00, rx_mem[reg_addr[OFF_W-1:0]]};
    endcase
  end

  assign irq    = |(stat_q & mask_q);
  assign sdo_oe = !tw_q || (running && (typ_q != XT_READ || idx_q < IDX_W'(pre_q)));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(running && slv_q == SEL_W'(g));
  end

  spi_pm_clkgen #(.PW(8)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(running), .period(per_q),
    .sck(sck), .sample(sample), .bit_end(bit_end)
  );

  spi_pm_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(ld_byte),
    .lsb_first(go_run ? cfg_q[7] : lsb_q), .sample(sample), .bit_end(bit_end),
    .sdi(sdi), .sdo(sdo), .rx_byte(rx_byte), .byte_done(byte_done)
  );
endmodule

// File: rtl/spi_pm_chk.sv
module spi_pm_chk #(
  parameter int NUM_CS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sck,
  input logic              irq,
  input logic              done_bit,
  input logic [4:0]        mask
);
  // R2: never more than one peripheral selected
  p_single_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R2: the selected line does not move while a transaction is open
  p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !(&$past(cs_n))) |-> (cs_n == $past(cs_n)));

  // R3: serial clock rests low outside a transaction
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);

  // R9: done is set when chip select is released
  p_done_at_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cs_n) && !(&$past(cs_n))) |-> done_bit);

  // R9: interrupt needs an enabled source
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != 5'd0));
endmodule

bind spi_prepend_master spi_pm_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .irq(irq),
  .done_bit(stat_q[0]), .mask(mask_q)
);

// File: tb/spi_prepend_master_tb.sv
module spi_prepend_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sck, sdo, sdo_oe, irq;
  logic        s_miso = 1'b0;
  logic [15:0] cs_n;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  spi_prepend_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .sdo(sdo),
    .sdo_oe(sdo_oe), .sdi(s_miso), .cs_n(cs_n), .irq(irq)
  );

  // peripheral model: replies with pat(k) for byte k of each transaction
  function automatic logic [7:0] pat(input int k);
    return 8'(8'hC3 ^ (k * 37));
  endfunction

  logic       s_lsb = 1'b0;
  logic [7:0] rec [128];
  logic [7:0] s_in = '0;
  int s_byte = 0, s_bit = 0, cs_falls = 0, cs_low_cyc = 0, oe_cyc = 0;
  wire cs_all = &cs_n;

  always @(negedge cs_all) begin
    cs_falls++;
    s_byte = 0;
    s_bit  = 0;
    s_miso = s_lsb ? pat(0)[0] : pat(0)[7];
  end
  always @(posedge sck) begin
    s_in = s_lsb ? {sdo, s_in[7:1]} : {s_in[6:0], sdo};
    s_bit++;
    if (s_bit == 8) begin
      rec[s_byte] = s_in;
      s_byte++;
      s_bit = 0;
    end
  end
  always @(negedge sck) begin
    s_miso = s_lsb ? pat(s_byte)[s_bit] : pat(s_byte)[7 - s_bit];
  end
  always @(negedge clk) begin
    if (!cs_all) cs_low_cyc++;
    if (!cs_all && sdo_oe) oe_cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input bit clr);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 20000 && !s[0]; i++) rd(8'h04, s);
    if (clr) wr(8'h04, 16'h0001);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [15:0] ctl, input logic [15:0] cmd);
    cs_low_cyc = 0;
    oe_cyc = 0;
    wr(8'h02, ctl);
    wr(8'h03, cmd);
    wait_done(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(cs_n == 16'hFFFF, "R1 cs", cs_n, 16'hFFFF);
    chk(sck == 1'b0, "R1 sck", sck, 0);
    rd(8'h04, d); chk(d == 0, "R1 status", d, 0);
    rd(8'h01, d); chk(d == 16'h00FF, "R1 fill", d, 16'hFF);
    rd(8'h00, d); chk(d == 16'h0010, "R1 cfg", d, 16'h10);

    // R3 rate sweep, R5 single write byte
    for (int c = 0; c < 8; c++) begin
      int p;
      p = (c == 0) ? 3 : (1 << (8 - c));
      wr(8'h00, 16'(c));
      wr(8'h40, 16'(8'h96 ^ c));
      run_cmd(16'h0041, 16'h0003);
      chk(cs_low_cyc == 8 * p, "R3 period", cs_low_cyc, 8 * p);
      chk(rec[0] == 8'(8'h96 ^ c), "R5 byte", rec[0], 8'h96 ^ c);
    end
    wr(8'h00, 16'h0007);

    // R6 full duplex
    for (int i = 0; i < 4; i++) wr(8'(8'h40 + i), 16'(8'h11 * (i + 1)));
    run_cmd(16'h0004, 16'h0003);
    for (int i = 0; i < 4; i++) begin
      chk(rec[i] == 8'(8'h11 * (i + 1)), "R6 tx", rec[i], 8'h11 * (i + 1));
      rd(8'(8'h80 + i), d); chk(d[7:0] == pat(i), "R6 rx", d, pat(i));
    end

    // R5 write only, rx untouched
    for (int i = 0; i < 3; i++) wr(8'(8'h40 + i), 16'(8'hE0 + i));
    run_cmd(16'h0043, 16'h0003);
    for (int i = 0; i < 3; i++) chk(rec[i] == 8'(8'hE0 + i), "R5 tx", rec[i], 8'hE0 + i);
    for (int i = 0; i < 4; i++) begin
      rd(8'(8'h80 + i), d); chk(d[7:0] == pat(i), "R5 rx kept", d, pat(i));
    end

    // R7 five prepend bytes then four reads
    wr(8'h01, 16'h005A);
    for (int i = 0; i < 5; i++) wr(8'(8'h40 + i), 16'(8'h03 + 8'h20 * i));
    f0 = cs_falls;
    run_cmd(16'h0084, 16'h0503);
    chk(cs_falls - f0 == 1, "R7 one window", cs_falls - f0, 1);
    chk(cs_low_cyc == 9 * 16, "R7 length", cs_low_cyc, 144);
    for (int i = 0; i < 5; i++)
      chk(rec[i] == 8'(8'h03 + 8'h20 * i), "R7 prepend", rec[i], 8'h03 + 8'h20 * i);
    for (int i = 5; i < 9; i++) chk(rec[i] == 8'h5A, "R7 fill", rec[i], 8'h5A);
    for (int i = 0; i < 4; i++) begin
      rd(8'(8'h80 + i), d); chk(d[7:0] == pat(i + 5), "R7 rx", d, pat(i + 5));
    end

    // R4 least significant bit first
    wr(8'h00, 16'h0087);
    s_lsb = 1'b1;
    wr(8'h40, 16'h0001); wr(8'h41, 16'h00C8);
    run_cmd(16'h0002, 16'h0003);
    chk(rec[0] == 8'h01, "R4 tx0", rec[0], 1);
    chk(rec[1] == 8'hC8, "R4 tx1", rec[1], 8'hC8);
    rd(8'h80, d); chk(d[7:0] == pat(0), "R4 rx0", d, pat(0));
    rd(8'h81, d); chk(d[7:0] == pat(1), "R4 rx1", d, pat(1));
    s_lsb = 1'b0;
    wr(8'h00, 16'h0007);

    // R8 3-wire turnaround
    wr(8'h40, 16'h00AB); wr(8'h41, 16'h00CD);
    run_cmd(16'h0082, 16'h1203);
    chk(oe_cyc == 32, "R8 oe 3wire", oe_cyc, 32);
    chk(cs_low_cyc == 64, "R8 length", cs_low_cyc, 64);
    wr(8'h40, 16'h00AB); wr(8'h41, 16'h00CD);
    run_cmd(16'h0082, 16'h0203);
    chk(oe_cyc == cs_low_cyc, "R8 oe 4wire", oe_cyc, cs_low_cyc);

    // R9 done, clear and mask
    wr(8'h05, 16'h0001);
    wr(8'h40, 16'h0055);
    wr(8'h02, 16'h0041); wr(8'h03, 16'h0003);
    wait_done(1'b0);
    chk(irq == 1'b1, "R9 irq on", irq, 1);
    wr(8'h04, 16'h0001);
    rd(8'h04, d); chk(d[0] == 1'b0, "R9 clear", d, 0);
    chk(irq == 1'b0, "R9 irq off", irq, 0);
    wr(8'h05, 16'h0000);
    wr(8'h40, 16'h0055);
    wr(8'h03, 16'h0003);
    wait_done(1'b0);
    chk(irq == 1'b0, "R9 masked", irq, 0);
    wr(8'h04, 16'h001F);

    // R10 overflow and underflow
    wr(8'h7F, 16'h0077);
    rd(8'h04, d); chk(d == 16'h0008, "R10 txover", d, 8);
    wr(8'h04, 16'h001F);
    wr(8'h40, 16'h0066);
    run_cmd(16'h0043, 16'h0003);
    rd(8'h04, d); chk(d == 16'h0004, "R10 txunder", d, 4);
    wr(8'h04, 16'h001F);

    // R11 and R2: busy start ignored, selected line
    wr(8'h00, 16'h0003);
    wr(8'h02, 16'h0042);
    f0 = cs_falls;
    wr(8'h03, 16'h0023);
    repeat (20) @(negedge clk);
    chk(cs_n == 16'hFFFB, "R2 select", cs_n, 16'hFFFB);
    wr(8'h03, 16'h0053);
    @(negedge clk);
    chk(cs_n == 16'hFFFB, "R11 busy", cs_n, 16'hFFFB);
    wait_done(1'b1);
    chk(cs_falls - f0 == 1, "R11 busy falls", cs_falls - f0, 1);
    // R11 cs-off gap: 7 x 2 cycles
    wr(8'h00, 16'h003F);
    wr(8'h02, 16'h0041);
    wr(8'h40, 16'h0011);
    f0 = cs_falls;
    wr(8'h03, 16'h0003);
    d = '0;
    for (int i = 0; i < 200 && !d[0]; i++) rd(8'h04, d);
    wr(8'h04, 16'h0001);
    wr(8'h03, 16'h0003);
    repeat (40) @(negedge clk);
    chk(cs_falls - f0 == 1, "R11 gap ignored", cs_falls - f0, 1);
    wr(8'h40, 16'h0011);
    wr(8'h03, 16'h0003);
    wait_done(1'b1);
    chk(cs_falls - f0 == 2, "R11 after gap", cs_falls - f0, 2);
    wr(8'h00, 16'h0007);
    repeat (20) @(negedge clk);

    // R2 other opcode, R12 type 3 and zero length
    wr(8'h04, 16'h001F);
    f0 = cs_falls;
    wr(8'h02, 16'h0041);
    wr(8'h03, 16'h0001);
    repeat (30) @(negedge clk);
    chk(cs_falls == f0, "R2 opcode", cs_falls - f0, 0);
    wr(8'h02, 16'h00C2);
    wr(8'h03, 16'h0003);
    repeat (30) @(negedge clk);
    rd(8'h04, d);
    chk(cs_falls == f0 && d[0] == 1'b0, "R12 type3", d, 0);
    wr(8'h02, 16'h0040);
    wr(8'h03, 16'h0003);
    repeat (2) @(negedge clk);
    rd(8'h04, d);
    chk(d[0] == 1'b1 && cs_falls == f0, "R12 zero", d, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule